// File: doc/BRIEF.md
# Banked Scratchpad Conflict Analyzer

This block inspects one request issued together by a group of 32 lanes against a 32-way banked on-chip scratchpad and reports how many serialized passes that request would need. Each bank is one 4-byte word wide. A lane supplies a byte address, and a shared mode input selects either a single-word access (4 bytes per lane) or a vector access (16 bytes per lane). A per-lane enable mask removes lanes from the request.

For every bank the analyzer counts the distinct word addresses that land on it. Lanes naming the same word are served by one read, so they share a pass. The worst bank sets the conflict degree. The block also reports a bitmap of the banks the request touches and a flag that is true when the request completes in at most one pass. It is intended as a side-band probe in a load/store pipeline or a layout-tuning harness. It does not service memory and carries no data.

The results are captured on the clock edge where the input strobe is high and appear with a one-cycle output strobe. They stay on the outputs until the next strobe.

Top module: `bank_conflict_analyzer`

## Requirements
- R1: In single-word mode (`vec_mode`=0) an active lane occupies bank `(addr >> 2) mod 32`, and address bits [1:0] are ignored.
- R2: In vector mode (`vec_mode`=1) an active lane occupies the four banks `4*addr[6:4]` through `4*addr[6:4]+3`, with word addresses `(addr >> 4)*4 + k` for k = 0..3. Address bits [3:0] are ignored.
- R3: `conflict_degree` equals the largest count, over all banks, of distinct word addresses mapped to that bank. Thirty-two lanes at a stride of 32 words report 32.
- R4: Active lanes that name the same word count once for that bank. Lane i reading word i reports a degree of 1.
- R5: Lanes whose `lane_active` bit is 0 have no effect on any output.
- R6: A strobed request with no active lane reports degree 0, `bank_busy` all zero and `conflict_free` 1.
- R7: Bit b of `bank_busy` is 1 exactly when at least one active lane occupies bank b.
- R8: `conflict_free` is 1 exactly when `conflict_degree` is 0 or 1.
- R9: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. The result outputs change only on such edges and otherwise hold their values. Back-to-back strobes each produce their own result.
- R10: While `rst_n` is low, `out_valid`=0, `conflict_degree`=0, `bank_busy`=0 and `conflict_free`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; inputs are captured on this edge |
| vec_mode | input | 1 | 0 = 4-byte access per lane, 1 = 16-byte access per lane |
| lane_active | input | 32 | Per-lane enable; bit i belongs to lane i |
| lane_addr | input | 1024 | Byte addresses; lane i uses bits [32*i+31:32*i] |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| conflict_degree | output | 6 | Worst-case passes over all banks (0 to 32) |
| bank_busy | output | 32 | Bit b set when any active lane occupies bank b |
| conflict_free | output | 1 | High when the degree is at most 1 |

## Verification
A fault in the duplicate-word filter shows up as a degree that is too high for broadcast patterns. A wrong bank index or vector expansion moves bits in `bank_busy` and changes the degree for stride patterns. Either appears on the ports in the `out_valid` cycle right after the offending strobe. A capture register that updates without a strobe shows up as a result that changes between strobes, and is visible on the first idle cycle. Because the results stay on the outputs between strobes, comparing them on every clock against an independent model exposes a wrong state within one cycle of the edge that created it.

// File: rtl/bca_pkg.sv
package bca_pkg;
  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic capture;   // register the analysis of the present inputs
    logic wideMode;  // interpret each lane as a 16-byte access
  } bcaStrobes_t;
endpackage

// File: rtl/bca_control.sv
module bca_control
  import bca_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        vecMode,
  output bcaStrobes_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe.capture  = inValid;
    strobe.wideMode = vecMode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

  // R9: output strobe follows each input strobe by exactly one cycle
  p_pulse_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
endmodule

// File: rtl/bca_datapath.sv
module bca_datapath
  import bca_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  bcaStrobes_t             strobe,
  input  logic [LANES*ADDR_W-1:0] laneAddr,
  input  logic [LANES-1:0]        laneActive,
  output logic [CNT_W-1:0]        degreeQ,
  output logic [BANKS-1:0]        busyQ,
  output logic                    freeQ
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int BANK_W = $clog2(BANKS);

  // Word address per lane; in vector mode the two low word bits are cleared
  // so the key names the first word of the 16-byte block.
  logic [LANES-1:0][WORD_W-1:0] laneKey;
  logic [LANES-1:0]             leadLane;
  logic [BANKS-1:0][CNT_W-1:0]  bankCnt;
  logic [BANKS-1:0]             busyNext;
  logic [CNT_W-1:0]             degreeNext;
  logic [LANES*2-1:0]           unusedLowBits;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneKey[i] = strobe.wideMode
      ? {laneAddr[i*ADDR_W+4 +: ADDR_W-4], 2'b00}
      : laneAddr[i*ADDR_W+2 +: WORD_W];
    assign unusedLowBits[i*2 +: 2] = laneAddr[i*ADDR_W +: 2];

    // A lane leads its word when no lower-numbered active lane names the
    // same word; only leaders are counted, which merges broadcasts.
    logic lead;
    always_comb begin
      lead = laneActive[i];
      for (int j = 0; j < i; j++) begin
        if (laneActive[j] && (laneKey[j] == laneKey[i])) lead = 1'b0;
      end
    end
    assign leadLane[i] = lead;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam logic [BANK_W-1:0] B_IDX = BANK_W'(b);
    logic [CNT_W-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int i = 0; i < LANES; i++) begin
        if (leadLane[i]) begin
          if (strobe.wideMode) begin
            if (laneKey[i][BANK_W-1:2] == B_IDX[BANK_W-1:2]) cnt = cnt + CNT_W'(1);
          end else begin
            if (laneKey[i][BANK_W-1:0] == B_IDX) cnt = cnt + CNT_W'(1);
          end
        end
      end
    end
    assign bankCnt[b]  = cnt;
    assign busyNext[b] = (cnt != '0);
  end

  always_comb begin
    degreeNext = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (bankCnt[b] > degreeNext) degreeNext = bankCnt[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      degreeQ <= '0;
      busyQ   <= '0;
      freeQ   <= 1'b1;
    end else if (strobe.capture) begin
      degreeQ <= degreeNext;
      busyQ   <= busyNext;
      freeQ   <= (degreeNext <= CNT_W'(1));
    end
  end

  // R6: an empty request yields an idle result
  p_empty_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture && laneActive == '0) |=> (degreeQ == '0 && busyQ == '0 && freeQ));
  // R4: a lone active lane can never conflict with itself
  p_single_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture && $countones(laneActive) == 1) |=> (degreeQ == CNT_W'(1)));
  // R7: the busy map is empty exactly when the degree is zero
  p_busy_vs_degree_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busyQ == '0) == (degreeQ == '0));
  // R3: the degree cannot exceed the number of lanes
  p_degree_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    degreeQ <= CNT_W'(LANES));
  // R9: results hold between strobes
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capture |=> ($stable(degreeQ) && $stable(busyQ) && $stable(freeQ)));
endmodule

// File: rtl/bank_conflict_analyzer.sv
module bank_conflict_analyzer
  import bca_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 32,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    vec_mode,
  input  logic [LANES-1:0]        lane_active,
  input  logic [LANES*ADDR_W-1:0] lane_addr,
  output logic                    out_valid,
  output logic [CNT_W-1:0]        conflict_degree,
  output logic [BANKS-1:0]        bank_busy,
  output logic                    conflict_free
);
  bcaStrobes_t strobe;

  bca_control u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (in_valid),
    .vecMode  (vec_mode),
    .strobe   (strobe),
    .outValid (out_valid)
  );

  bca_datapath #(
    .LANES (LANES),
    .BANKS (BANKS),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .laneAddr  (lane_addr),
    .laneActive(lane_active),
    .degreeQ   (conflict_degree),
    .busyQ     (bank_busy),
    .freeQ     (conflict_free)
  );
endmodule

// File: tb/bank_conflict_analyzer_tb_top.sv
module bank_conflict_analyzer_tb_top;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          vec_mode = 1'b0;
  logic [31:0]   lane_active = '0;
  logic [1023:0] lane_addr;
  logic          out_valid;
  logic [5:0]    conflict_degree;
  logic [31:0]   bank_busy;
  logic          conflict_free;

  logic [31:0] addrs [32];
  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string curTag = "R10";

  always #5 clk = ~clk;

  always_comb for (int i = 0; i < 32; i++) lane_addr[i*32 +: 32] = addrs[i];

  bank_conflict_analyzer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vec_mode(vec_mode),
    .lane_active(lane_active), .lane_addr(lane_addr), .out_valid(out_valid),
    .conflict_degree(conflict_degree), .bank_busy(bank_busy),
    .conflict_free(conflict_free));

  // Reference model: collect the unique words of the request, then tally per bank.
  int          refDeg;
  logic [31:0] refBusy;
  function automatic void refModel();
    int unsigned words[$];
    int cnt;
    refDeg = 0;
    refBusy = '0;
    for (int i = 0; i < 32; i++) begin
      if (lane_active[i]) begin
        for (int k = 0; k < (vec_mode ? 4 : 1); k++) begin
          int unsigned w;
          bit seen;
          w = vec_mode ? ((addrs[i] >> 4) * 4 + k) : (addrs[i] >> 2);
          seen = 0;
          foreach (words[n]) if (words[n] == w) seen = 1;
          if (!seen) words.push_back(w);
        end
      end
    end
    for (int b = 0; b < 32; b++) begin
      cnt = 0;
      foreach (words[n]) if (words[n] % 32 == b) cnt++;
      if (cnt > 0) refBusy[b] = 1'b1;
      if (cnt > refDeg) refDeg = cnt;
    end
  endfunction

  logic        expValid;
  int          expDeg;
  logic [31:0] expBusy;
  logic        expFree;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expValid <= 1'b0; expDeg <= 0; expBusy <= '0; expFree <= 1'b1;
    end else begin
      expValid <= in_valid;
      if (in_valid) begin
        refModel();
        expDeg  <= refDeg;
        expBusy <= refBusy;
        expFree <= (refDeg <= 1);
      end
    end
  end

  // Compare every output on every falling edge.
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out_valid !== expValid) begin
        failures++;
        $display("FAIL %s out_valid got %0d exp %0d", curTag, out_valid, expValid);
      end
      checks++;
      if (int'(conflict_degree) != expDeg || ^conflict_degree === 1'bx) begin
        failures++;
        $display("FAIL %s conflict_degree got %0d exp %0d", curTag, conflict_degree, expDeg);
      end
      checks++;
      if (bank_busy !== expBusy) begin
        failures++;
        $display("FAIL %s bank_busy got %h exp %h", curTag, bank_busy, expBusy);
      end
      checks++;
      if (conflict_free !== expFree) begin
        failures++;
        $display("FAIL %s conflict_free got %0d exp %0d", curTag, conflict_free, expFree);
      end
    end
  end

  task automatic send();
    @(negedge clk); #1;
    in_valid = 1'b1;
    @(negedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic setPattern(int base, int strideBytes, bit vec, logic [31:0] mask);
    for (int i = 0; i < 32; i++) addrs[i] = 32'(base + i * strideBytes);
    vec_mode = vec;
    lane_active = mask;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) addrs[i] = '0;
    curTag = "R10";                            // reset values
    idle(3);
    rst_n = 1'b1;
    idle(2);

    curTag = "R1";                             // contiguous words, bank = word mod 32
    setPattern(32'h100, 4, 0, '1); send(); idle(1);
    setPattern(32'h13, 4, 0, 32'h0000_00FF); send(); idle(1);

    curTag = "R3";                             // stride of 32 words -> 32
    setPattern(0, 128, 0, '1); send(); idle(1);
    setPattern(64, 256, 0, '1); send(); idle(1);

    curTag = "R4";                             // broadcast of one word
    setPattern(32'h40, 0, 0, '1); send(); idle(1);
    for (int i = 0; i < 32; i++) addrs[i] = 32'((i % 4) * 128 + (i % 3));
    send(); idle(1);

    curTag = "R2";                             // 16-byte lanes, four banks each
    setPattern(0, 16, 1, '1); send(); idle(1);
    for (int i = 0; i < 32; i++) addrs[i] = 32'(i * 128 + (i % 16));
    lane_active = 32'h0000_000F; send(); idle(1);
    setPattern(32'h200, 0, 1, '1); send(); idle(1);

    curTag = "R5";                             // inactive lanes ignored
    setPattern(0, 128, 0, 32'h5555_5555); send(); idle(1);
    setPattern(0, 4, 0, 32'h0000_0001);
    for (int i = 1; i < 32; i++) addrs[i] = 32'(i * 128);
    send(); idle(1);

    curTag = "R6";                             // nothing active
    setPattern(0, 128, 1, '0); send(); idle(1);

    curTag = "R9";                             // hold without strobe, then back-to-back
    setPattern(0, 128, 0, '1); send();
    setPattern(0, 4, 0, '1); idle(4);
    @(negedge clk); #1; in_valid = 1'b1;
    @(negedge clk); #1; setPattern(0, 256, 1, '1);
    @(negedge clk); #1; in_valid = 1'b0;
    idle(2);

    curTag = "R7";                             // random mixes for busy map and flag
    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < 32; i++) addrs[i] = $urandom & 32'h0000_07FF;
      vec_mode = $urandom_range(0, 1) == 1;
      lane_active = $urandom;
      if (t % 5 == 0) lane_active = lane_active & 32'h0101_0101;
      curTag = (t % 2 == 0) ? "R7" : "R8";
      send();
    end
    idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired got running exp finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule